// File: doc/BRIEF.md
# Sigma-delta decimation filter with saturating output

This block turns the one-bit stream of a fourth-order sigma-delta modulator into 16-bit two's-complement samples. The modulator runs 64 times faster than the output rate. The block takes one input bit on every eighth master clock. After every 64 input bits it delivers one output word, so a new sample appears once every 512 master clocks. A one-cycle strobe marks each new word, and the word is held until the next strobe.

The filter is a fourth-order cascaded integrator-comb structure. The integrators run at the bit rate and wrap freely. The comb sections run at the output rate. The full-scale filter value is scaled down to the 16-bit range. One unscaled result does not fit that range: a stream of all ones gives exactly +2^24, which scales to +32768. When a result falls outside the range, the block clamps the word to the 16-bit limit. It also raises an overflow pulse in the same cycle as the sample strobe, so the value does not wrap silently.

Top module: `sd_decimator`

## Requirements
- R1: While `rst_n` is low, `sample`, `sample_valid` and `overflow` are all 0. They go to 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: `sample_valid` is a one-cycle pulse that repeats every 512 clocks. After `rst_n` rises, the first pulse appears in the cycle that follows the 514th rising clock edge. This is two cycles of reset synchronisation plus 512 cycles.
- R3: `bit_in` is sampled once every 8 clocks. A 1 counts as +1 and a 0 counts as -1. For a 64-periodic input stream, the settled output depends only on how many ones the period contains, not on where they sit in the period.
- R4: Take a 64-periodic stream with k ones per period, where 1 <= k <= 63, held for at least five output periods. Every later `sample` equals (2k - 64) * 512, and `overflow` stays 0.
- R5: A steady all-ones stream produces the unscaled value +2^24. This saturates `sample` to +32767 (0x7FFF), and `overflow` is 1 in the strobe cycle. The unscaled comb result never goes beyond +/-2^24, and every overflow output equals one of the two 16-bit limits.
- R6: A steady all-zeros stream gives `sample` = -32768 (0x8000) with `overflow` at 0. The lower limit is reached without saturation.
- R7: `overflow` is never 1 outside a `sample_valid` cycle, and it lasts a single cycle.
- R8: `sample` changes only in cycles where `sample_valid` is 1. Between strobes it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| bit_in | input | 1 | Modulator bit stream, taken once every 8 clocks |
| sample | output | 16 | Decimated two's-complement sample, held between strobes |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| overflow | output | 1 | One-cycle pulse, given with the strobe, when the sample was clamped |

## Verification
The hardest case to reach from the ports is a settled filter state in which the output can be predicted exactly. The bit-sampling phase is internal, and the filter has a long memory spanning several output periods. The stimulus therefore repeats one 64-bit pattern for eight output periods, holding each bit for eight clocks. It compares only periods five and six of each pattern, where every tap sees the pattern whatever its phase. Patterns include contiguous and evenly spread arrangements of the ones. They also include the all-ones and all-zeros extremes, which reach the saturating upper limit and the exactly representable lower limit.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  // Classification of a scaled filter result against the output range
  typedef enum logic [1:0] {
    RANGE_OK   = 2'd0,
    RANGE_HIGH = 2'd1,
    RANGE_LOW  = 2'd2
  } range_e;

  // Accumulator width for a CIC of the given order and ratio: the full-scale
  // gain is 2^(order*ratio_log2), plus a sign bit and a bit for +full-scale.
  function automatic int acc_width(input int order, input int ratio_log2);
    return order * ratio_log2 + 2;
  endfunction

endpackage

// File: rtl/dcm_rst_sync.sv
module dcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dcm_timebase.sv
module dcm_timebase #(
  parameter int FRAME_LOG2   = 9,
  parameter int BIT_DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_en,
  output logic frame_en
);

  logic [FRAME_LOG2-1:0] cnt_q;
  logic [FRAME_LOG2-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + FRAME_LOG2'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign bit_en   = &cnt_q[BIT_DIV_LOG2-1:0];
  assign frame_en = &cnt_q;

  // The output frame boundary must coincide with a bit slot (R3)
  assert_frame_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |-> bit_en);

  // Bit slots are never back to back (R3)
  assert_bit_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en);

endmodule

// File: rtl/dcm_integ_chain.sv
module dcm_integ_chain #(
  parameter int ORDER = 4,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);

  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_q [ORDER];
  logic [ACC_W-1:0] acc_d [ORDER];

  // A one maps to +1, a zero to -1 (all ones in two's complement)
  always_comb begin
    step = bit_in ? ACC_W'(1) : '1;
  end

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic [ACC_W-1:0] addend;

    if (i == 0) begin : g_first
      assign addend = step;
    end else begin : g_next
      assign addend = acc_q[i-1];
    end

    always_comb begin
      acc_d[i] = acc_q[i];
      if (en) begin
        acc_d[i] = acc_q[i] + addend;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
      end else begin
        acc_q[i] <= acc_d[i];
      end
    end
  end

  assign acc_out = acc_q[ORDER-1];

endmodule

// File: rtl/dcm_comb_chain.sv
module dcm_comb_chain #(
  parameter int ORDER = 4,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);

  logic [ORDER:0][ACC_W-1:0] stage;
  logic [ACC_W-1:0]          dly_q [ORDER];
  logic [ACC_W-1:0]          dly_d [ORDER];

  assign stage[0] = din;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    assign stage[i+1] = stage[i] - dly_q[i];

    always_comb begin
      dly_d[i] = dly_q[i];
      if (en) begin
        dly_d[i] = stage[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q[i] <= '0;
      end else begin
        dly_q[i] <= dly_d[i];
      end
    end
  end

  assign dout = stage[ORDER];

endmodule

// File: rtl/dcm_sat_out.sv
module dcm_sat_out
  import dcm_pkg::*;
#(
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 16,
  parameter int FS_LOG2 = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ACC_W-1:0]        din,
  output logic signed [OUT_W-1:0] sample,
  output logic                    valid,
  output logic                    ovf
);

  localparam int SHIFT = FS_LOG2 - (OUT_W - 1);
  localparam int SC_W  = ACC_W - SHIFT;
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] FS_POS =
    {{(ACC_W-FS_LOG2-1){1'b0}}, 1'b1, {FS_LOG2{1'b0}}};
  localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

  logic [SC_W-1:0]        scaled;
  logic [SC_W-OUT_W:0]    guard;
  range_e                 range_sel;
  logic [OUT_W-1:0]       sample_q, sample_d;
  logic                   valid_q, valid_d;
  logic                   ovf_q, ovf_d;

  // Arithmetic scaling: keep the upper bits of the comb result
  always_comb begin
    scaled = din[ACC_W-1:SHIFT];
    guard  = scaled[SC_W-1:OUT_W-1];
    if ((&guard) || !(|guard)) begin
      range_sel = RANGE_OK;
    end else if (!scaled[SC_W-1]) begin
      range_sel = RANGE_HIGH;
    end else begin
      range_sel = RANGE_LOW;
    end
  end

  always_comb begin
    sample_d = sample_q;
    valid_d  = 1'b0;
    ovf_d    = 1'b0;
    if (en) begin
      valid_d = 1'b1;
      unique case (range_sel)
        RANGE_HIGH: begin sample_d = OUT_MAX; ovf_d = 1'b1; end
        RANGE_LOW:  begin sample_d = OUT_MIN; ovf_d = 1'b1; end
        default:    begin sample_d = scaled[OUT_W-1:0]; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      sample_q <= sample_d;
      valid_q  <= valid_d;
      ovf_q    <= ovf_d;
    end
  end

  assign sample = sample_q;
  assign valid  = valid_q;
  assign ovf    = ovf_q;

  // Strobe lasts one cycle (R2)
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // Overflow only accompanies a strobe (R7)
  assert_ovf_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> valid_q);

  // A clamped word sits exactly on a 16-bit limit (R5)
  assert_ovf_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (sample_q == OUT_MAX || sample_q == OUT_MIN));

  // The comb result never leaves the filter's full-scale range (R5)
  assert_comb_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($signed(din) <= FS_POS && $signed(din) >= FS_NEG));

  // The sample word only moves together with a strobe (R8)
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_q) |-> valid_q);

endmodule

// File: rtl/sd_decimator.sv
module sd_decimator #(
  parameter int ORDER        = 4,
  parameter int RATIO_LOG2   = 6,
  parameter int BIT_DIV_LOG2 = 3,
  parameter int OUT_W        = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_in,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid,
  output logic                    overflow
);

  localparam int ACC_W      = dcm_pkg::acc_width(ORDER, RATIO_LOG2);
  localparam int FRAME_LOG2 = RATIO_LOG2 + BIT_DIV_LOG2;
  localparam int FS_LOG2    = ORDER * RATIO_LOG2;

  logic             srst_n;
  logic             bit_en;
  logic             frame_en;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_out;

  dcm_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dcm_timebase #(
    .FRAME_LOG2   (FRAME_LOG2),
    .BIT_DIV_LOG2 (BIT_DIV_LOG2)
  ) u_tb (
    .clk      (clk),
    .rst_n    (srst_n),
    .bit_en   (bit_en),
    .frame_en (frame_en)
  );

  dcm_integ_chain #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_integ (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (bit_en),
    .bit_in  (bit_in),
    .acc_out (integ_out)
  );

  dcm_comb_chain #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_comb (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (frame_en),
    .din   (integ_out),
    .dout  (comb_out)
  );

  dcm_sat_out #(
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .FS_LOG2 (FS_LOG2)
  ) u_out (
    .clk    (clk),
    .rst_n  (srst_n),
    .en     (frame_en),
    .din    (comb_out),
    .sample (sample),
    .valid  (sample_valid),
    .ovf    (overflow)
  );

endmodule

// File: tb/sd_decimator_test.sv
`timescale 1ns/1ps
module sd_decimator_test;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bit_in = 1'b0;
  logic signed [15:0] sample;
  logic               sample_valid;
  logic               overflow;

  int checks = 0;
  int errors = 0;

  int    exp_q[$];
  bit    ovf_q[$];
  bit    chk_q[$];
  string req_q[$];

  bit          mon_on = 1'b0;
  bit          first_seen = 1'b0;
  bit          was_valid = 1'b0;
  int          since_rel = 0;
  int          cyc = 0;
  int          last_valid = 0;
  logic signed [15:0] prev_sample = '0;

  sd_decimator uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (bit_in),
    .sample       (sample),
    .sample_valid (sample_valid),
    .overflow     (overflow)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) since_rel = 0;
    else        since_rel = since_rel + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items at each strobe and compares
  always @(negedge clk) begin
    if (mon_on) begin
      if (sample_valid) begin
        if (!first_seen) begin
          first_seen = 1'b1;
          check("R2", "first strobe cycle after release", since_rel, 514);
        end else begin
          check("R2", "strobe spacing", cyc - last_valid, 512);
        end
        last_valid = cyc;
        if (exp_q.size() > 0) begin
          int    e;
          bit    eo;
          bit    c;
          string r;
          e  = exp_q.pop_front();
          eo = ovf_q.pop_front();
          c  = chk_q.pop_front();
          r  = req_q.pop_front();
          if (c) begin
            check(r, "sample", int'(sample), e);
            check(r, "overflow flag", int'(overflow), int'(eo));
          end
        end
      end else begin
        if (was_valid) begin
          check("R7", "strobe and flag after strobe cycle",
                int'({sample_valid, overflow}), 0);
          check("R8", "sample held after strobe", int'(sample), int'(prev_sample));
        end else begin
          if (overflow) check("R7", "overflow without strobe", 1, 0);
          if (sample !== prev_sample)
            check("R8", "sample moved between strobes", int'(sample), int'(prev_sample));
        end
      end
      was_valid   = sample_valid;
      prev_sample = sample;
    end
  end

  // Driver: pushes one expected item per output period, drives 64 bits
  task automatic run_pattern(input string req, input int k, input bit spread, input int nframes);
    for (int f = 0; f < nframes; f++) begin
      int e;
      bit eo;
      e  = (2 * k - 64) * 512;
      eo = 1'b0;
      if (e > 32767) begin
        e  = 32767;
        eo = 1'b1;
      end
      exp_q.push_back(e);
      ovf_q.push_back(eo);
      chk_q.push_back(f >= 5 && f <= nframes - 2);
      req_q.push_back(req);
      for (int j = 0; j < 64; j++) begin
        bit b;
        b = spread ? (((j + 1) * k) / 64 != (j * k) / 64) : (j < k);
        bit_in = b;
        repeat (8) @(negedge clk);
      end
    end
  endtask

  task automatic check_reset_state(input string what);
    check("R1", {what, " sample"}, int'(sample), 0);
    check("R1", {what, " strobe"}, int'(sample_valid), 0);
    check("R1", {what, " overflow"}, int'(overflow), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("during reset");
    rst_n  = 1'b1;
    mon_on = 1'b1;

    run_pattern("R4", 32, 1'b0, 8);   // balanced: 0
    run_pattern("R4", 48, 1'b0, 8);   // 16384
    run_pattern("R3", 48, 1'b1, 8);   // same count, spread: 16384
    run_pattern("R3", 40, 1'b1, 8);   // 8192
    run_pattern("R4", 63, 1'b0, 8);   // 31744, largest unclamped
    run_pattern("R5", 64, 1'b0, 8);   // all ones: clamp to 32767
    run_pattern("R6", 0, 1'b0, 8);    // all zeros: -32768, no clamp
    run_pattern("R4", 1, 1'b1, 8);    // -31744

    // Reset in the middle of activity clears the outputs at once
    @(negedge clk);
    while (!sample_valid) @(negedge clk);
    mon_on = 1'b0;
    #3 rst_n = 1'b0;
    #1 check_reset_state("asynchronous clear");
    repeat (4) @(negedge clk);
    check_reset_state("held in reset");

    exp_q.delete();
    ovf_q.delete();
    chk_q.delete();
    req_q.delete();
    first_seen  = 1'b0;
    was_valid   = 1'b0;
    prev_sample = '0;
    rst_n  = 1'b1;
    mon_on = 1'b1;
    run_pattern("R4", 16, 1'b0, 8);   // -16384 after restart

    mon_on = 1'b0;
    finish_run();
  end

endmodule